// File: doc/BRIEF.md
# Cascaded Masked Interrupt Controller

This block merges a set of interrupt request lines into one level-sensitive request for a processor. The lines are split at a fixed boundary index. Lines below the boundary carry level requests from devices, and their status bits show the live input. Lines at or above the boundary carry DMA events. An event sets a status bit, and that bit stays set until software clears it.

Software sees two 32-bit registers through a simple read/write port. The status register is at byte offset 0 and the enable mask is at byte offset 4. A latched event is cleared by writing a word with a 0 in that bit and 1 in every other bit. Each DMA event is either informational or error class, and a constant parameter marks the five informational lines. An error-class event also raises a halt signal to its DMA channel. The halt stays up until the status bit is cleared. Informational events never halt their channel.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: While reset is held and after it is released, the mask reads 0, every latched DMA status bit is 0, `cpu_irq` is 0 and every `dma_halt` bit is 0.
- R2: A write to address 4 loads the whole mask from `reg_wdata` at the clock edge. A read of address 4 returns the mask.
- R3: For an index i below the boundary (default 16), status bit i always equals `irq_in[i]`. A status write does not change it.
- R4: For an index at or above the boundary, a 1 on `irq_in` sets the latched status bit in the cycle after the edge. The bit stays 1 after the input falls.
- R5: A write to address 0 clears each latched DMA bit whose `reg_wdata` bit is 0. Latched bits whose `reg_wdata` bit is 1 keep their value.
- R6: If a DMA event arrives in the same cycle as a clear of that bit, the bit stays 1.
- R7: `cpu_irq` is 1 exactly when some status bit and its mask bit are both 1. A zero mask keeps `cpu_irq` at 0.
- R8: `dma_halt[j]` belongs to line boundary+j. For an error-class line it equals the latched status bit and drops in the cycle after the clearing write. For an informational line (mask parameter bits 16, 18, 22, 23, 29 by default) it is always 0.
- R9: Only the aligned addresses 0 and 4 are decoded. A write to any other address changes nothing. A read of any other address returns 0. Reads are combinational from `reg_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_in | input | 32 | Request lines: device levels below the boundary, DMA event lines above it |
| reg_addr | input | 3 | Byte address of the register access |
| reg_wr_en | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| cpu_irq | output | 1 | Combined level request to the processor |
| dma_halt | output | 16 | Halt request per DMA channel, one bit per line above the boundary |

## Verification
The assertions assume that `reg_wr_en`, `reg_addr` and `irq_in` are known values at every clock edge. They also assume the internal reset has been released, because every property is disabled while it is low. The bench drives every input at the falling edge and samples one time unit later, so no input changes near the active edge. Events and clears are applied one bit at a time, in bulk patterns, and in the same cycle as each other, so that the event-wins case is exercised at the port boundary.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned REG_ADDR_W = 3;
  localparam logic [REG_ADDR_W-1:0] ADDR_STATUS = 3'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_MASK   = 3'd4;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_MASK   = 2'd2
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [REG_ADDR_W-1:0] a);
    if (a == ADDR_STATUS)    return SEL_STATUS;
    else if (a == ADDR_MASK) return SEL_MASK;
    else                     return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_regport.sv
module irq_regport
  import irq_cascade_pkg::*;
#(
  parameter int unsigned NLINES = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr_en,
  input  logic [NLINES-1:0]     reg_wdata,
  input  logic [NLINES-1:0]     status_vec,
  output logic [NLINES-1:0]     reg_rdata,
  output logic [NLINES-1:0]     mask_q,
  output logic                  status_wr
);
  reg_sel_e          sel;
  logic              mask_en;
  logic [NLINES-1:0] mask_d;

  always_comb begin
    sel       = decode_sel(reg_addr);
    mask_en   = reg_wr_en && (sel == SEL_MASK);
    status_wr = reg_wr_en && (sel == SEL_STATUS);
    mask_d    = mask_en ? reg_wdata : mask_q;
    unique case (sel)
      SEL_STATUS: reg_rdata = status_vec;
      SEL_MASK:   reg_rdata = mask_q;
      default:    reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else        mask_q <= mask_d;
  end

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mask_en |=> (mask_q == $past(reg_wdata)));
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr != ADDR_MASK) |=> $stable(mask_q));
endmodule

// File: rtl/irq_dma_latch.sv
module irq_dma_latch #(
  parameter int unsigned NUM_DMA = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_DMA-1:0] evt_in,
  input  logic               clr_en,
  input  logic [NUM_DMA-1:0] keep_bits,
  output logic [NUM_DMA-1:0] evt_q
);
  logic [NUM_DMA-1:0] evt_d;

  for (genvar i = 0; i < NUM_DMA; i++) begin : g_bit
    logic hold;
    always_comb begin
      hold     = clr_en ? keep_bits[i] : 1'b1;
      evt_d[i] = evt_in[i] | (evt_q[i] & hold);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_q[i] <= 1'b0;
      else        evt_q[i] <= evt_d[i];
    end

    p_evt_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_in[i] |=> evt_q[i]);
    p_evt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !keep_bits[i] && !evt_in[i]) |=> !evt_q[i]);
    p_evt_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !(clr_en && !keep_bits[i])) |=> evt_q[i]);
    p_evt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_en && !keep_bits[i] && evt_in[i]) |=> evt_q[i]);
  end
endmodule

// File: rtl/irq_combine.sv
module irq_combine #(
  parameter int unsigned NLINES    = 32,
  parameter int unsigned DMA_BASE  = 16,
  parameter logic [NLINES-1:0] INFO_MASK = 32'h20C5_0000,
  localparam int unsigned NUM_DMA = NLINES - DMA_BASE
) (
  input  logic [NLINES-1:0]  status_vec,
  input  logic [NLINES-1:0]  mask_q,
  input  logic [NUM_DMA-1:0] evt_q,
  output logic               cpu_irq,
  output logic [NUM_DMA-1:0] dma_halt
);
  always_comb cpu_irq = |(status_vec & mask_q);

  for (genvar j = 0; j < NUM_DMA; j++) begin : g_halt
    if (INFO_MASK[DMA_BASE+j]) begin : g_info
      assign dma_halt[j] = 1'b0;
    end else begin : g_err
      assign dma_halt[j] = evt_q[j];
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_cascade_pkg::*;
#(
  parameter int unsigned NLINES    = 32,
  parameter int unsigned DMA_BASE  = 16,
  parameter logic [NLINES-1:0] INFO_MASK = 32'h20C5_0000,
  localparam int unsigned NUM_DMA = NLINES - DMA_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINES-1:0]     irq_in,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr_en,
  input  logic [NLINES-1:0]     reg_wdata,
  output logic [NLINES-1:0]     reg_rdata,
  output logic                  cpu_irq,
  output logic [NUM_DMA-1:0]    dma_halt
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [NLINES-1:0]  status_vec;
  logic [NLINES-1:0]  mask_q;
  logic [NUM_DMA-1:0] evt_q;
  logic               status_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign status_vec = {evt_q, irq_in[DMA_BASE-1:0]};

  irq_regport #(.NLINES(NLINES)) u_regport (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .reg_addr   (reg_addr),
    .reg_wr_en  (reg_wr_en),
    .reg_wdata  (reg_wdata),
    .status_vec (status_vec),
    .reg_rdata  (reg_rdata),
    .mask_q     (mask_q),
    .status_wr  (status_wr)
  );

  irq_dma_latch #(.NUM_DMA(NUM_DMA)) u_latch (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .evt_in    (irq_in[NLINES-1:DMA_BASE]),
    .clr_en    (status_wr),
    .keep_bits (reg_wdata[NLINES-1:DMA_BASE]),
    .evt_q     (evt_q)
  );

  irq_combine #(
    .NLINES    (NLINES),
    .DMA_BASE  (DMA_BASE),
    .INFO_MASK (INFO_MASK)
  ) u_combine (
    .status_vec (status_vec),
    .mask_q     (mask_q),
    .evt_q      (evt_q),
    .cpu_irq    (cpu_irq),
    .dma_halt   (dma_halt)
  );

  p_quiet_mask_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mask_q == '0) |-> !cpu_irq);
  p_reset_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_int_n) |-> (mask_q == '0 && evt_q == '0));

  for (genvar j = 0; j < NUM_DMA; j++) begin : g_chk
    if (!INFO_MASK[DMA_BASE+j]) begin : g_err
      p_halt_release_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        (reg_wr_en && reg_addr == ADDR_STATUS && !reg_wdata[DMA_BASE+j]
         && !irq_in[DMA_BASE+j]) |=> !dma_halt[j]);
    end else begin : g_info
      p_info_no_halt_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
        irq_in[DMA_BASE+j] |=> !dma_halt[j]);
    end
  end
endmodule

// File: tb/irq_cascade_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_cascade_ctrl_tb_top;
  localparam logic [31:0] INFO = 32'h20C5_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] irq_in;
  logic [2:0]  reg_addr;
  logic        reg_wr_en;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        cpu_irq;
  logic [15:0] dma_halt;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] exp_lat;
  logic [31:0] exp_mask;

  always #4 clk = ~clk;

  irq_cascade_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .dma_halt(dma_halt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a == 3'd0) exp_lat = exp_lat & d[31:16];
    if (a == 3'd4) exp_mask = d;
    #1;
  endtask

  task automatic pulse(input logic [15:0] bits);
    @(negedge clk);
    irq_in[31:16] = bits;
    @(negedge clk);
    irq_in[31:16] = '0;
    exp_lat = exp_lat | bits;
    #1;
  endtask

  function automatic logic [15:0] exp_halt();
    return exp_lat & ~INFO[31:16];
  endfunction

  function automatic logic exp_irq();
    return |({exp_lat, irq_in[15:0]} & exp_mask);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; irq_in = '0; reg_addr = '0; reg_wr_en = 1'b0; reg_wdata = '0;
    exp_lat = '0; exp_mask = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 halt in reset", {16'h0, dma_halt}, 32'h0);
    chk("R1 irq in reset", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, d); chk("R1 mask after reset", d, 32'h0);
    rd(3'd0, d); chk("R1 status after reset", d, 32'h0);
    chk("R1 irq after reset", {31'h0, cpu_irq}, 32'h0);

    // R2: walking ones and patterns through the mask
    for (int i = 0; i < 32; i++) begin
      wr(3'd4, 32'h1 << i);
      rd(3'd4, d); chk("R2 mask walk", d, 32'h1 << i);
    end
    wr(3'd4, 32'hA5C3_0F96); rd(3'd4, d); chk("R2 mask pattern", d, 32'hA5C3_0F96);
    // R9: unaligned and unused addresses
    for (int a = 1; a < 8; a++) begin
      if (a != 4) begin
        wr(a[2:0], 32'h0);
        rd(3'd4, d); chk("R9 stray write ignored", d, 32'hA5C3_0F96);
        rd(a[2:0], d); chk("R9 stray read zero", d, 32'h0);
      end
    end
    wr(3'd4, 32'h0);

    // R3 and R7 over the device lines
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); irq_in[i] = 1'b1;
      rd(3'd0, d); chk("R3 level follows", d, {exp_lat, 16'h1 << i});
      chk("R7 masked off", {31'h0, cpu_irq}, 32'h0);
      wr(3'd0, 32'h0);
      rd(3'd0, d); chk("R3 write no effect", d, {exp_lat, 16'h1 << i});
      wr(3'd4, 32'h1 << i);
      chk("R7 enabled device", {31'h0, cpu_irq}, {31'h0, exp_irq()});
      wr(3'd4, 32'hFFFF_FFFF ^ (32'h1 << i));
      chk("R7 other bits only", {31'h0, cpu_irq}, {31'h0, exp_irq()});
      wr(3'd4, 32'h0);
      @(negedge clk); irq_in[i] = 1'b0;
      rd(3'd0, d); chk("R3 level drops", d, 32'h0);
    end

    // R4 R5 R7 R8 over each DMA line
    for (int j = 0; j < 16; j++) begin
      pulse(16'h1 << j);
      rd(3'd0, d); chk("R4 latched after pulse", d, {exp_lat, 16'h0});
      chk("R8 halt set", {16'h0, dma_halt}, {16'h0, exp_halt()});
      chk("R7 masked event", {31'h0, cpu_irq}, 32'h0);
      wr(3'd4, 32'h1 << (16 + j));
      chk("R7 enabled event", {31'h0, cpu_irq}, 32'h1);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, d); chk("R5 ones keep", d, {exp_lat, 16'h0});
      wr(3'd0, ~(32'h1 << (16 + j)));
      rd(3'd0, d); chk("R5 zero clears", d, 32'h0);
      chk("R8 halt released", {16'h0, dma_halt}, 32'h0);
      chk("R7 drops after clear", {31'h0, cpu_irq}, 32'h0);
      wr(3'd4, 32'h0);
    end

    // R5 bulk: clear alternate bits
    pulse(16'hFFFF);
    chk("R8 bulk halt", {16'h0, dma_halt}, {16'h0, ~INFO[31:16]});
    wr(3'd0, 32'hAAAA_FFFF);
    rd(3'd0, d); chk("R5 bulk partial clear", d, 32'hAAAA_0000);
    chk("R8 bulk halt after clear", {16'h0, dma_halt}, {16'h0, exp_halt()});

    // R6: event in same cycle as clear wins
    for (int j = 0; j < 16; j += 5) begin
      @(negedge clk);
      reg_addr = 3'd0; reg_wdata = ~(32'h1 << (16 + j)); reg_wr_en = 1'b1;
      irq_in[16 + j] = 1'b1;
      @(negedge clk);
      reg_wr_en = 1'b0; irq_in[16 + j] = 1'b0;
      exp_lat = (exp_lat & reg_wdata[31:16]) | (16'h1 << j);
      rd(3'd0, d); chk("R6 event wins", d, {exp_lat, 16'h0});
    end
    wr(3'd0, 32'h0000_FFFF);
    rd(3'd0, d); chk("R5 clear all", d, 32'h0);
    chk("R8 no halt at end", {16'h0, dma_halt}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule